// File: doc/BRIEF.md
# Dual-Descriptor Byte DMA Channel

This block is a single DMA channel that carries bytes between system memory and a byte-wide peripheral. Software prepares up to two buffer descriptors ("slot A" and "slot B"), marks them valid, and the engine works through them one after the other in ping-pong order. In one direction it reads memory one byte at a time and hands each byte to the peripheral. In the other it takes bytes from the peripheral and writes them to memory. Memory is reached through a single-byte request/acknowledge port, and the peripheral through valid/ready handshakes in each direction.

Each 64-bit descriptor holds a byte address, a byte count and a flag that marks the final buffer of a stream. When a flagged buffer has fully drained, the peripheral receives a one-cycle terminal-count strobe. A buffer must stay inside one 4096-byte page. An inbound buffer must also start on a 64-byte boundary. A descriptor that breaks either rule is dropped and a memory-error interrupt is raised. Software can freeze the channel, hold it in soft reset, read a diagnostic word with the current slot, activity and bytes left, and clear the level interrupts by writing ones to them.

Top module: `pingpong_byte_dma`

## Requirements
- R1: A descriptor word holds the start address in bits 31:0, the byte count in bits 43:32 and the final-buffer flag in bit 63. Register word 0 holds slot A and word 1 holds slot B. Reads return the addressed word one cycle after the address is presented.
- R2: With control bit 0 clear, the engine reads the buffer bytes from ascending addresses and passes each one to the peripheral in order. Only one byte is in flight at a time. A memory request stays up until it is acknowledged, and an offered byte stays stable until the peripheral takes it.
- R3: With control bit 0 set, each byte accepted from the peripheral is written to the next ascending memory address. The engine never holds a memory request while offering or accepting a peripheral byte.
- R4: Control (word 2) bit 4 marks slot A valid and bit 3 marks slot B valid. After reset the engine starts on slot A. When a slot finishes, the engine clears that slot's valid bit, raises that slot's done interrupt, and moves to the other slot if that slot is valid. Otherwise it waits until a valid bit is set. A software write to the control word in the same cycle as a clear takes precedence.
- R5: When a finished slot has the final-buffer flag set, the terminal-count output pulses high for exactly one cycle. A slot without the flag produces no pulse.
- R6: If the low 12 address bits plus the count exceed 4096, the slot is dropped. No byte moves, the valid bit is cleared, the memory-error interrupt is raised and no done interrupt is raised. A buffer that ends exactly on the page boundary is legal.
- R7: An inbound slot whose address bits 5:0 are not zero is treated as a memory error, as in R6. An outbound slot may start at any byte address.
- R8: A slot with a count of zero finishes without any byte transfer and still raises its done interrupt.
- R9: Control bit 1 is the enable. While it is 0, no new byte is started and no idle slot is picked up. Setting it to 1 resumes the channel from where it stopped.
- R10: While control bit 2 is 1, the channel is held in soft reset. Both valid bits read 0 and software writes cannot set them. The remaining count is 0, the engine is idle on slot A, and it drops any memory request or peripheral offer. Interrupt levels are kept.
- R11: The diagnostic word (word 3) is read-only. Bit 0 is the current slot (0 = A, 1 = B). Bit 1 is 1 when the channel is enabled and not idle. Bits 13:2 hold the bytes still to move in the current buffer.
- R12: The interrupt word (word 4) carries done A in bit 0, done B in bit 1 and memory error in bit 2. These also drive the three interrupt outputs as levels. Writing 1 to a bit clears it. A new event in the same cycle as a clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word index |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data, one cycle after the address |
| mem_req | output | 1 | Memory byte request, held until acknowledged |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Memory acknowledge (read data valid in the same cycle) |
| mem_rdata | input | 8 | Byte read from memory |
| dev_out_valid | output | 1 | Byte offered to the peripheral |
| dev_out_data | output | 8 | Outbound byte |
| dev_out_ready | input | 1 | Peripheral takes the outbound byte |
| dev_in_valid | input | 1 | Peripheral offers an inbound byte |
| dev_in_data | input | 8 | Inbound byte |
| dev_in_ready | output | 1 | Engine takes the inbound byte |
| irq_done_a | output | 1 | Slot A done interrupt level |
| irq_done_b | output | 1 | Slot B done interrupt level |
| irq_merr | output | 1 | Memory error interrupt level |
| tc_pulse | output | 1 | One-cycle terminal-count strobe to the peripheral |

## Verification
The interrupt latch can receive a completion event from the engine and a write-one-to-clear from software in the same cycle. A first run times a zero-length slot A from the control write to the moment its done bit shows. A second, identical run places the clear write so that it lands on exactly that cycle. The done bit must still read 1 afterwards, which shows that the event won, and a later ordinary clear must bring it to 0.

// File: rtl/ctxdma_pkg.sv
package ctxdma_pkg;

  // register word indices
  localparam logic [2:0] RW_SLOT_A = 3'd0;
  localparam logic [2:0] RW_SLOT_B = 3'd1;
  localparam logic [2:0] RW_CTRL   = 3'd2;
  localparam logic [2:0] RW_DIAG   = 3'd3;
  localparam logic [2:0] RW_IRQ    = 3'd4;

  // descriptor field placement (software decodes these positions)
  localparam int DESC_W    = 64;
  localparam int COUNT_LSB = 32;
  localparam int FINAL_BIT = 63;

  // control word, bit 4 down to bit 0
  typedef struct packed {
    logic vld_a;
    logic vld_b;
    logic srst;
    logic en;
    logic dir;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_START,
    ST_MEM,
    ST_DOUT,
    ST_DIN,
    ST_FIN
  } eng_state_t;

endpackage

// File: rtl/ctxdma_guard.sv
module ctxdma_guard #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 12,
  parameter int PAGE_W  = 12,
  parameter int ALIGN_W = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              inbound,
  output logic              bad
);
  localparam int SUM_W = ((PAGE_W > LEN_W) ? PAGE_W : LEN_W) + 1;

  logic [SUM_W-1:0] end_off;
  logic [SUM_W-1:0] page_size;
  logic             crosses;
  logic             misaligned;

  assign page_size = SUM_W'(1) << PAGE_W;
  assign end_off   = SUM_W'(base[PAGE_W-1:0]) + SUM_W'(len);
  assign crosses   = end_off > page_size;

  generate
    if (ALIGN_W > 0) begin : g_align
      assign misaligned = inbound && (base[ALIGN_W-1:0] != '0);
    end else begin : g_noalign
      assign misaligned = 1'b0;
    end
  endgenerate

  assign bad = crosses | misaligned;
endmodule

// File: rtl/ctxdma_regs.sv
module ctxdma_regs
  import ctxdma_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [2:0]        csr_addr,
  input  logic [DESC_W-1:0] csr_wdata,
  output logic [DESC_W-1:0] csr_rdata,
  output logic [DESC_W-1:0] slot_a,
  output logic [DESC_W-1:0] slot_b,
  output ctrl_t             ctrl,
  input  logic              fin_evt,
  input  logic              fin_err,
  input  logic              fin_slot,
  input  logic              diag_slot,
  input  logic              diag_busy,
  input  logic [LEN_W-1:0]  diag_cnt,
  output logic [2:0]        irq
);
  localparam int DIAG_PAD = DESC_W - LEN_W - 2;

  ctrl_t      ctrl_nxt;
  logic [2:0] irq_set;
  logic [2:0] irq_clr;

  always_comb begin
    ctrl_nxt = ctrl;
    if (csr_we && csr_addr == RW_CTRL) begin
      ctrl_nxt = ctrl_t'(csr_wdata[4:0]);
    end else if (fin_evt) begin
      if (fin_slot) ctrl_nxt.vld_b = 1'b0;
      else          ctrl_nxt.vld_a = 1'b0;
    end
    if (ctrl_nxt.srst) begin
      ctrl_nxt.vld_a = 1'b0;
      ctrl_nxt.vld_b = 1'b0;
    end
  end

  assign irq_set = {fin_evt & fin_err,
                    fin_evt & ~fin_err & fin_slot,
                    fin_evt & ~fin_err & ~fin_slot};
  assign irq_clr = (csr_we && csr_addr == RW_IRQ) ? csr_wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_a <= '0;
      slot_b <= '0;
      ctrl   <= '0;
      irq    <= '0;
    end else begin
      if (csr_we && csr_addr == RW_SLOT_A) slot_a <= csr_wdata;
      if (csr_we && csr_addr == RW_SLOT_B) slot_b <= csr_wdata;
      ctrl <= ctrl_nxt;
      irq  <= (irq & ~irq_clr) | irq_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
    end else begin
      case (csr_addr)
        RW_SLOT_A: csr_rdata <= slot_a;
        RW_SLOT_B: csr_rdata <= slot_b;
        RW_CTRL:   csr_rdata <= {{(DESC_W-5){1'b0}}, ctrl};
        RW_DIAG:   csr_rdata <= {{DIAG_PAD{1'b0}}, diag_cnt, diag_busy, diag_slot};
        RW_IRQ:    csr_rdata <= {{(DESC_W-3){1'b0}}, irq};
        default:   csr_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ctxdma_engine.sv
module ctxdma_engine
  import ctxdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [DESC_W-1:0] slot_a,
  input  logic [DESC_W-1:0] slot_b,
  input  logic              desc_bad,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_cnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              tc_pulse,
  output logic              fin_evt,
  output logic              fin_err,
  output logic              cur_slot,
  output logic              busy
);
  eng_state_t        state;
  logic              final_q;
  logic              err_q;
  logic [1:0]        vld;
  logic              pick;
  logic [DESC_W-1:0] pick_desc;
  logic              last_byte;

  assign vld       = {ctrl.vld_b, ctrl.vld_a};
  assign pick      = vld[cur_slot] ? cur_slot : ~cur_slot;
  assign pick_desc = pick ? slot_b : slot_a;
  assign last_byte = (cur_cnt == LEN_W'(1));

  assign fin_evt = (state == ST_FIN);
  assign fin_err = err_q;
  assign busy    = ctrl.en && (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst || ctrl.srst) begin
      state         <= ST_IDLE;
      cur_slot      <= 1'b0;
      cur_addr      <= '0;
      cur_cnt       <= '0;
      final_q       <= 1'b0;
      err_q         <= 1'b0;
      mem_req       <= 1'b0;
      mem_we        <= 1'b0;
      mem_wdata     <= '0;
      dev_out_valid <= 1'b0;
      dev_out_data  <= '0;
      dev_in_ready  <= 1'b0;
      tc_pulse      <= 1'b0;
    end else begin
      tc_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ctrl.en && (vld != 2'b00)) begin
            cur_slot <= pick;
            cur_addr <= pick_desc[ADDR_W-1:0];
            cur_cnt  <= pick_desc[COUNT_LSB +: LEN_W];
            final_q  <= pick_desc[FINAL_BIT];
            err_q    <= 1'b0;
            state    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (cur_cnt == '0) begin
            tc_pulse <= final_q;
            state    <= ST_FIN;
          end else if (desc_bad) begin
            err_q   <= 1'b1;
            cur_cnt <= '0;
            state   <= ST_FIN;
          end else begin
            state <= ST_START;
          end
        end
        ST_START: begin
          if (ctrl.en) begin
            if (ctrl.dir) begin
              dev_in_ready <= 1'b1;
              state        <= ST_DIN;
            end else begin
              mem_req <= 1'b1;
              mem_we  <= 1'b0;
              state   <= ST_MEM;
            end
          end
        end
        ST_DIN: begin
          if (dev_in_valid) begin
            dev_in_ready <= 1'b0;
            mem_wdata    <= dev_in_data;
            mem_req      <= 1'b1;
            mem_we       <= 1'b1;
            state        <= ST_MEM;
          end
        end
        ST_MEM: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            if (!mem_we) begin
              dev_out_data  <= mem_rdata;
              dev_out_valid <= 1'b1;
              state         <= ST_DOUT;
            end else begin
              cur_addr <= cur_addr + ADDR_W'(1);
              cur_cnt  <= cur_cnt - LEN_W'(1);
              tc_pulse <= last_byte && final_q;
              state    <= last_byte ? ST_FIN : ST_START;
            end
          end
        end
        ST_DOUT: begin
          if (dev_out_ready) begin
            dev_out_valid <= 1'b0;
            cur_addr      <= cur_addr + ADDR_W'(1);
            cur_cnt       <= cur_cnt - LEN_W'(1);
            tc_pulse      <= last_byte && final_q;
            state         <= last_byte ? ST_FIN : ST_START;
          end
        end
        ST_FIN: begin
          if (vld[~cur_slot]) cur_slot <= ~cur_slot;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_byte_dma.sv
module pingpong_byte_dma
  import ctxdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 12,
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 12,
  parameter int ALIGN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [2:0]        csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              irq_done_a,
  output logic              irq_done_b,
  output logic              irq_merr,
  output logic              tc_pulse
);
  logic [DESC_W-1:0] slot_a;
  logic [DESC_W-1:0] slot_b;
  ctrl_t             ctrl_w;
  logic              fin_evt;
  logic              fin_err;
  logic              cur_slot;
  logic              busy;
  logic [LEN_W-1:0]  cur_cnt;
  logic [ADDR_W-1:0] cur_addr;
  logic              desc_bad;
  logic [2:0]        irq;

  ctxdma_regs #(.LEN_W(LEN_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .slot_a    (slot_a),
    .slot_b    (slot_b),
    .ctrl      (ctrl_w),
    .fin_evt   (fin_evt),
    .fin_err   (fin_err),
    .fin_slot  (cur_slot),
    .diag_slot (cur_slot),
    .diag_busy (busy),
    .diag_cnt  (cur_cnt),
    .irq       (irq)
  );

  ctxdma_guard #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .PAGE_W (PAGE_W),
    .ALIGN_W(ALIGN_W)
  ) i_guard (
    .base    (cur_addr),
    .len     (cur_cnt),
    .inbound (ctrl_w.dir),
    .bad     (desc_bad)
  );

  ctxdma_engine #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .DATA_W(DATA_W)
  ) i_engine (
    .clk           (clk),
    .rst           (rst),
    .ctrl          (ctrl_w),
    .slot_a        (slot_a),
    .slot_b        (slot_b),
    .desc_bad      (desc_bad),
    .cur_addr      (cur_addr),
    .cur_cnt       (cur_cnt),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .dev_out_valid (dev_out_valid),
    .dev_out_data  (dev_out_data),
    .dev_out_ready (dev_out_ready),
    .dev_in_valid  (dev_in_valid),
    .dev_in_data   (dev_in_data),
    .dev_in_ready  (dev_in_ready),
    .tc_pulse      (tc_pulse),
    .fin_evt       (fin_evt),
    .fin_err       (fin_err),
    .cur_slot      (cur_slot),
    .busy          (busy)
  );

  assign mem_addr   = cur_addr;
  assign irq_done_a = irq[0];
  assign irq_done_b = irq[1];
  assign irq_merr   = irq[2];
endmodule

// File: rtl/ctxdma_checker.sv
module ctxdma_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_srst,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              dev_out_valid,
  input logic              dev_out_ready,
  input logic [DATA_W-1:0] dev_out_data,
  input logic              dev_in_ready,
  input logic              tc_pulse,
  input logic              irq_done_a,
  input logic              irq_merr,
  input logic              csr_we,
  input logic [2:0]        csr_addr,
  input logic [63:0]       csr_wdata
);
  assert_tc_single_R5: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (dev_out_valid && !dev_out_ready && !ctl_srst) |=> (dev_out_valid && $stable(dev_out_data)));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !ctl_srst) |=> mem_req);

  assert_one_inflight_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && (dev_out_valid || dev_in_ready)));

  assert_srst_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    ctl_srst |=> (!mem_req && !dev_out_valid && !dev_in_ready));

  assert_done_w1c_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_done_a) |-> $past(csr_we && csr_addr == 3'd4 && csr_wdata[0]));

  assert_merr_w1c_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_merr) |-> $past(csr_we && csr_addr == 3'd4 && csr_wdata[2]));
endmodule

bind pingpong_byte_dma ctxdma_checker #(.DATA_W(DATA_W)) i_checker (
  .clk           (clk),
  .rst           (rst),
  .ctl_srst      (ctrl_w.srst),
  .mem_req       (mem_req),
  .mem_ack       (mem_ack),
  .dev_out_valid (dev_out_valid),
  .dev_out_ready (dev_out_ready),
  .dev_out_data  (dev_out_data),
  .dev_in_ready  (dev_in_ready),
  .tc_pulse      (tc_pulse),
  .irq_done_a    (irq_done_a),
  .irq_merr      (irq_merr),
  .csr_we        (csr_we),
  .csr_addr      (csr_addr),
  .csr_wdata     (csr_wdata)
);

// File: tb/test_pingpong_byte_dma.sv
module test_pingpong_byte_dma;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        dev_out_valid;
  logic [7:0]  dev_out_data;
  logic        dev_out_ready;
  logic        dev_in_valid;
  logic [7:0]  dev_in_data;
  logic        dev_in_ready;
  logic        irq_done_a, irq_done_b, irq_merr, tc_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench models
  logic       sink_rdy = 1'b1;
  logic [7:0] sink_mem [0:63];
  int         sink_n = 0;
  int         tc_n = 0;
  int         wr_n = 0;
  logic [7:0] wmem [0:8191];
  logic [7:0] src_mem [0:63];
  int         src_n = 0;
  int         src_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dev_out_ready = sink_rdy;
  assign dev_in_valid  = (src_idx < src_n);
  assign dev_in_data   = src_mem[src_idx % 64];

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'((a * 13) + 7);
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        wmem[mem_addr[12:0]] <= mem_wdata;
        wr_n <= wr_n + 1;
      end else begin
        mem_rdata <= pat(mem_addr);
      end
    end else begin
      mem_ack <= 1'b0;
    end
    if (dev_out_valid && dev_out_ready) begin
      sink_mem[sink_n % 64] <= dev_out_data;
      sink_n <= sink_n + 1;
    end
    if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;
    if (tc_pulse) tc_n <= tc_n + 1;
  end

  pingpong_byte_dma i_pingpong_byte_dma (
    .clk(clk), .rst(rst),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .irq_done_a(irq_done_a), .irq_done_b(irq_done_b), .irq_merr(irq_merr), .tc_pulse(tc_pulse)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    csr_addr = a;
    @(negedge clk);
    d = csr_rdata;
  endtask

  function automatic logic [63:0] desc(input logic [31:0] base, input int len, input bit fin);
    return {fin, 19'b0, 12'(len), base};
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_irq();
    csr_write(3'd4, 64'h7);
  endtask

  // R13-free reset view: R10 / R11 / R12 at power-up
  task automatic t_reset();
    logic [63:0] d;
    csr_read(3'd4, d); check("R12 irq word after reset", d, 64'h0);
    csr_read(3'd3, d); check("R11 diag after reset", d, 64'h0);
    csr_read(3'd2, d); check("R4 control after reset", d, 64'h0);
    check("R12 irq pins after reset", {irq_merr, irq_done_b, irq_done_a}, 3'b000);
  endtask

  // R1 R2 R7: outbound from odd address, no final flag
  task automatic t_out_basic();
    logic [63:0] d;
    int s0 = sink_n, t0 = tc_n;
    csr_write(3'd0, desc(32'h103, 5, 1'b0));
    csr_read(3'd0, d); check("R1 slot A readback", d, desc(32'h103, 5, 1'b0));
    csr_write(3'd2, 64'h12);
    settle(60);
    check("R2 byte count outbound", 64'(sink_n - s0), 64'd5);
    for (int i = 0; i < 5; i++)
      check("R2 R7 outbound byte", sink_mem[(s0 + i) % 64], pat(32'h103 + 32'(i)));
    csr_read(3'd4, d); check("R4 done A raised", d, 64'h1);
    csr_read(3'd2, d); check("R4 valid A cleared", d, 64'h02);
    check("R5 no pulse without flag", 64'(tc_n - t0), 64'd0);
    clear_irq();
  endtask

  // R4 R5: both slots valid, A first then B, B is final
  task automatic t_pingpong();
    logic [63:0] d;
    int s0 = sink_n, t0 = tc_n;
    csr_write(3'd0, desc(32'h200, 3, 1'b0));
    csr_write(3'd1, desc(32'h300, 2, 1'b1));
    csr_write(3'd2, 64'h1A);
    settle(80);
    check("R4 total bytes both slots", 64'(sink_n - s0), 64'd5);
    for (int i = 0; i < 3; i++)
      check("R4 slot A bytes first", sink_mem[(s0 + i) % 64], pat(32'h200 + 32'(i)));
    for (int i = 0; i < 2; i++)
      check("R4 slot B bytes second", sink_mem[(s0 + 3 + i) % 64], pat(32'h300 + 32'(i)));
    csr_read(3'd4, d); check("R4 both done bits", d, 64'h3);
    check("R5 one terminal pulse", 64'(tc_n - t0), 64'd1);
    csr_read(3'd2, d); check("R4 both valid cleared", d, 64'h02);
    clear_irq();
  endtask

  // R4 R11: only B valid, engine switches to B and stays there
  task automatic t_only_b();
    logic [63:0] d;
    int s0 = sink_n;
    csr_write(3'd1, desc(32'h400, 2, 1'b0));
    csr_write(3'd2, 64'h0A);
    settle(40);
    check("R4 switch to lone B", 64'(sink_n - s0), 64'd2);
    csr_read(3'd4, d); check("R4 done B only", d, 64'h2);
    check("R12 done B pin", irq_done_b, 1'b1);
    csr_read(3'd3, d); check("R11 diag shows slot B idle", d, 64'h1);
    clear_irq();
  endtask

  // R3: inbound into aligned buffer
  task automatic t_inbound();
    logic [63:0] d;
    logic [7:0] bytes [4] = '{8'hA5, 8'h5A, 8'h3C, 8'hC3};
    for (int i = 0; i < 4; i++) src_mem[(src_n + i) % 64] = bytes[i];
    src_n = src_n + 4;
    csr_write(3'd0, desc(32'h240, 4, 1'b0));
    csr_write(3'd2, 64'h13);
    settle(60);
    for (int i = 0; i < 4; i++)
      check("R3 inbound byte stored", wmem[13'h240 + 13'(i)], bytes[i]);
    csr_read(3'd4, d); check("R3 done A after inbound", d, 64'h1);
    clear_irq();
  endtask

  // R7: misaligned inbound start
  task automatic t_misalign();
    logic [63:0] d;
    int w0 = wr_n;
    csr_write(3'd0, desc(32'h241, 2, 1'b0));
    csr_write(3'd2, 64'h13);
    settle(30);
    csr_read(3'd4, d); check("R7 misaligned inbound merr", d, 64'h4);
    check("R7 no memory writes", 64'(wr_n - w0), 64'd0);
    csr_read(3'd2, d); check("R7 valid A cleared", d, 64'h03);
    clear_irq();
  endtask

  // R6: page crossing and exact page end
  task automatic t_page();
    logic [63:0] d;
    int s0 = sink_n;
    csr_write(3'd0, desc(32'hFFE, 4, 1'b0));
    csr_write(3'd2, 64'h12);
    settle(30);
    csr_read(3'd4, d); check("R6 crossing raises merr", d, 64'h4);
    check("R6 crossing moves nothing", 64'(sink_n - s0), 64'd0);
    clear_irq();
    csr_write(3'd0, desc(32'hFFC, 4, 1'b0));
    csr_write(3'd2, 64'h12);
    settle(50);
    check("R6 exact page end legal", 64'(sink_n - s0), 64'd4);
    check("R6 last byte of page", sink_mem[(s0 + 3) % 64], pat(32'hFFF));
    csr_read(3'd4, d); check("R6 done on page end", d, 64'h1);
    clear_irq();
  endtask

  // R8 R5: zero-length with final flag
  task automatic t_zero();
    logic [63:0] d;
    int s0 = sink_n, t0 = tc_n;
    csr_write(3'd0, desc(32'h700, 0, 1'b1));
    csr_write(3'd2, 64'h12);
    settle(20);
    check("R8 zero length no bytes", 64'(sink_n - s0), 64'd0);
    csr_read(3'd4, d); check("R8 zero length done", d, 64'h1);
    check("R5 pulse on flagged empty slot", 64'(tc_n - t0), 64'd1);
    clear_irq();
  endtask

  // R9 R11: frozen channel, then resume
  task automatic t_freeze();
    logic [63:0] d;
    int s0 = sink_n;
    csr_write(3'd0, desc(32'h500, 3, 1'b0));
    csr_write(3'd2, 64'h10);
    settle(40);
    check("R9 frozen moves nothing", 64'(sink_n - s0), 64'd0);
    csr_read(3'd3, d); check("R11 frozen not active", 64'(d[1]), 64'd0);
    csr_read(3'd4, d); check("R9 frozen no irq", d, 64'h0);
    csr_write(3'd2, 64'h12);
    settle(50);
    check("R9 resumes after enable", 64'(sink_n - s0), 64'd3);
    clear_irq();
  endtask

  // R11 R10: stalled peripheral, diag mid-buffer, then soft reset
  task automatic t_diag_srst();
    logic [63:0] d;
    int s0;
    sink_rdy = 1'b0;
    csr_write(3'd0, desc(32'h600, 4, 1'b0));
    csr_write(3'd2, 64'h12);
    settle(20);
    csr_read(3'd3, d); check("R11 diag mid buffer", d, 64'h12);
    csr_write(3'd2, 64'h16);
    csr_read(3'd2, d); check("R10 valid forced low in soft reset", d, 64'h06);
    csr_read(3'd3, d); check("R10 diag cleared in soft reset", d, 64'h0);
    s0 = sink_n;
    sink_rdy = 1'b1;
    settle(5);
    csr_write(3'd2, 64'h00);
    settle(10);
    check("R10 offer dropped", 64'(sink_n - s0), 64'd0);
    csr_read(3'd4, d); check("R10 no done after soft reset", d, 64'h0);
  endtask

  // R12: event and clear in the same cycle
  task automatic t_collide();
    logic [63:0] d;
    int c = 0;
    csr_write(3'd0, desc(32'h800, 0, 1'b0));
    csr_write(3'd2, 64'h12);
    while (!irq_done_a && c < 50) begin @(negedge clk); c++; end
    check("R12 dry run saw done", irq_done_a, 1'b1);
    clear_irq();
    settle(2);
    csr_write(3'd2, 64'h12);
    repeat (c - 1) @(negedge clk);
    csr_we = 1'b1; csr_addr = 3'd4; csr_wdata = 64'h1;
    @(negedge clk);
    csr_we = 1'b0;
    settle(2);
    csr_read(3'd4, d); check("R12 set wins over same-cycle clear", d, 64'h1);
    clear_irq();
    csr_read(3'd4, d); check("R12 write one clears", d, 64'h0);
    check("R12 pin low after clear", irq_done_a, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_out_basic();
    t_pingpong();
    t_only_b();
    t_inbound();
    t_misalign();
    t_page();
    t_zero();
    t_freeze();
    t_diag_srst();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule